// File: doc/BRIEF.md
# Link Power Status Monitor

This block sits between a PHY-side port controller and its link layer. It watches the link-power-status input, which the link drives, and uses it to decide whether the PHY-to-link interface runs normally, is held in reset, or is shut down. The status input first passes through a synchroniser. After that, a low-duration counter measures how long the input has stayed low, against two thresholds.

- **Reset threshold.** When the low time reaches the shorter threshold, the interface enters reset. The two control lines and the eight data lines are forced to zero, but the clock to the link keeps running.
- **Disable threshold.** When the low time reaches the longer threshold, the interface is disabled. The link clock enable also drops, so the link clock stops.

When the status input returns high, the behaviour depends on the current state:

- **From reset:** the interface becomes active again straight away.
- **From disable:** the block first enters a restoring state. The link clock runs again but the outputs stay low. The block becomes active only after a setup interval has passed.

All intervals are parameters given in cycles of the local clock. The defaults assume a 125 MHz clock (8 ns period).

Top module: `link_power_monitor`

## Requirements
- R1: The interface enters reset (state_o = 1) after status_i has been sampled low on RESET_CYC consecutive clock edges. With status_i held low, state_o changes on edge RESET_CYC+3 counted from the drop, and not on edge RESET_CYC+2. The default 250 cycles gives 2.024 µs, which lies inside 1.2–2.75 µs.
- R2: ctl_o follows ctl_i and dat_o follows dat_i only while state_o = 0 (active). In every other state, both ctl_o and dat_o are all zeros.
- R3: While state_o = 1 (reset), link_clk_en_o stays high.
- R4: With status_i held low, the block enters disable (state_o = 2) with link_clk_en_o low on edge DISABLE_CYC+3 after the drop, and not on edge DISABLE_CYC+2. The default 3375 cycles gives 27.02 µs, which lies inside 25–30 µs.
- R5: A low period shorter than RESET_CYC samples leaves state_o unchanged. Any high sample clears the accumulated low time, so two such pulses split by a single high sample still leave the state active.
- R6: From reset, status_i returning high brings state_o back to 0 on the third clock edge, which is well within 1 µs.
- R7: From disable, status_i returning high gives state_o = 3 (restoring) with link_clk_en_o high on the third edge. It then gives state_o = 0 after RESTORE_CYC further edges. The default 2125 cycles gives 17 µs.
- R8: A low sample during restoring restarts the restore interval from zero. The block becomes active RESTORE_CYC+2 edges after the edge that sampled the low.
- R9: A synchronous reset (rst_i high at a clock edge) puts the block in disable, with link_clk_en_o low and all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running local clock |
| rst_i | input | 1 | Synchronous reset, active high |
| status_i | input | 1 | Asynchronous link power status (high = link powered) |
| ctl_i | input | CTL_W | Control values the PHY drives when active |
| dat_i | input | DATA_W | Data values the PHY drives when active |
| ctl_o | output | CTL_W | Control lines toward the link, zero unless active |
| dat_o | output | DATA_W | Data lines toward the link, zero unless active |
| link_clk_en_o | output | 1 | Enable for the clock supplied to the link |
| state_o | output | 2 | 0 active, 1 reset, 2 disable, 3 restoring |

## Verification
The status input is driven with several kinds of low period:

- **Held lows.** These are stopped exactly one edge before and one edge after each threshold. They separate a correct reset or disable threshold from an off-by-one one.
- **Short pulses.** These are one sample below the reset threshold and come in pairs separated by one high sample. They show whether the low counter really clears on a high sample or keeps accumulating.
- **Restore runs.** One runs uninterrupted and one is interrupted by a single-sample glitch. Together they show whether a glitch restarts the setup interval, and whether restoring keeps the clock on while holding the outputs low.

Data passthrough is compared in the active state against the same patterns forced to zero in the other states.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      LPM_ACTIVE  = 2'd0,
      LPM_RESET   = 2'd1,
      LPM_DISABLE = 2'd2,
      LPM_RESTORE = 2'd3
   } lpm_state_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) chain[0] <= 1'b0;
               else       chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) chain[gi] <= 1'b0;
               else       chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer #(
   parameter int SHORT_CYC = 250,
   parameter int LONG_CYC  = 3375
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic short_hit_o,
   output logic long_hit_o
);
   localparam int CNT_W = $clog2(LONG_CYC + 1);
   localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
   localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk_i) begin
      if (rst_i || level_i)       low_cnt <= '0;
      else if (low_cnt != LONG_LIM) low_cnt <= low_cnt + 1'b1;
   end

   assign short_hit_o = (low_cnt >= SHORT_LIM);
   assign long_hit_o  = (low_cnt == LONG_LIM);
endmodule

// File: rtl/lpm_restore_timer.sv
module lpm_restore_timer #(
   parameter int SETUP_CYC = 2125
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = $clog2(SETUP_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETUP_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done_o = run_i && (cnt == LAST);
endmodule

// File: rtl/link_power_monitor.sv
module link_power_monitor
   import lpm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RESET_CYC   = 250,
   parameter int DISABLE_CYC = 3375,
   parameter int RESTORE_CYC = 2125,
   parameter int CTL_W       = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              status_i,
   input  logic [CTL_W-1:0]  ctl_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [DATA_W-1:0] dat_o,
   output logic              link_clk_en_o,
   output logic [1:0]        state_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (RESET_CYC < 1) begin : g_bad_reset
         $error("RESET_CYC must be positive");
      end
      if (DISABLE_CYC <= RESET_CYC) begin : g_bad_disable
         $error("DISABLE_CYC must exceed RESET_CYC");
      end
      if (RESTORE_CYC < 2) begin : g_bad_restore
         $error("RESTORE_CYC must be at least 2");
      end
   endgenerate

   logic       lps_sync;
   logic       reset_hit;
   logic       disable_hit;
   logic       restore_done;
   lpm_state_e state_q, state_d;

   lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (status_i),
      .q_o   (lps_sync)
   );

   lpm_low_timer #(.SHORT_CYC(RESET_CYC), .LONG_CYC(DISABLE_CYC)) u_low (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .level_i     (lps_sync),
      .short_hit_o (reset_hit),
      .long_hit_o  (disable_hit)
   );

   lpm_restore_timer #(.SETUP_CYC(RESTORE_CYC)) u_rest (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .run_i  ((state_q == LPM_RESTORE) && lps_sync),
      .done_o (restore_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LPM_ACTIVE: begin
            if (disable_hit)    state_d = LPM_DISABLE;
            else if (reset_hit) state_d = LPM_RESET;
         end
         LPM_RESET: begin
            if (lps_sync)         state_d = LPM_ACTIVE;
            else if (disable_hit) state_d = LPM_DISABLE;
         end
         LPM_DISABLE: begin
            if (lps_sync) state_d = LPM_RESTORE;
         end
         LPM_RESTORE: begin
            if (reset_hit)         state_d = LPM_RESET;
            else if (restore_done) state_d = LPM_ACTIVE;
         end
         default: state_d = LPM_DISABLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= LPM_DISABLE;
      else       state_q <= state_d;
   end

   assign ctl_o         = (state_q == LPM_ACTIVE) ? ctl_i : '0;
   assign dat_o         = (state_q == LPM_ACTIVE) ? dat_i : '0;
   assign link_clk_en_o = (state_q != LPM_DISABLE);
   assign state_o       = state_q;
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker
   import lpm_pkg::*;
#(
   parameter int CTL_W  = 2,
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              lps_sync,
   input logic [CTL_W-1:0]  ctl_o,
   input logic [DATA_W-1:0] dat_o,
   input logic              link_clk_en_o,
   input logic [1:0]        state_o
);
   assert_outputs_quiet_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o != LPM_ACTIVE) |-> (ctl_o == '0 && dat_o == '0));

   assert_clock_kept_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == LPM_RESET) |-> link_clk_en_o);

   assert_clock_stopped_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == LPM_DISABLE) |-> !link_clk_en_o);

   assert_disable_exit_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == LPM_DISABLE) |=> (state_o == LPM_DISABLE || state_o == LPM_RESTORE));

   assert_restore_clock_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == LPM_RESTORE) |-> link_clk_en_o);

   assert_reset_exit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == LPM_RESET && lps_sync) |=> (state_o == LPM_ACTIVE));

   assert_sync_reset_R9: assert property (@(posedge clk_i)
      rst_i |=> (state_o == LPM_DISABLE && !link_clk_en_o));
endmodule

bind link_power_monitor lpm_checker #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_lpm_checker (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .lps_sync      (lps_sync),
   .ctl_o         (ctl_o),
   .dat_o         (dat_o),
   .link_clk_en_o (link_clk_en_o),
   .state_o       (state_o)
);

// File: tb/link_power_monitor_bench.sv
module link_power_monitor_bench;
   localparam int RC = 250;
   localparam int DC = 3375;
   localparam int TC = 2125;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       status = 1'b1;
   logic [1:0] ctl_in = 2'b10;
   logic [7:0] dat_in = 8'hA5;
   logic [1:0] ctl_out;
   logic [7:0] dat_out;
   logic       clk_en;
   logic [1:0] state;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   link_power_monitor u_link_power_monitor (
      .clk_i(clk), .rst_i(rst), .status_i(status),
      .ctl_i(ctl_in), .dat_i(dat_in),
      .ctl_o(ctl_out), .dat_o(dat_out),
      .link_clk_en_o(clk_en), .state_o(state)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_quiet(input string req);
      check(req, int'(ctl_out), 0);
      check(req, int'(dat_out), 0);
   endtask

   task automatic t_sync_reset;
      @(negedge clk); rst = 1'b1;
      edges(1);
      check("R9 state", int'(state), 2);
      check("R9 clk_en", int'(clk_en), 0);
      expect_quiet("R9 outputs");
      rst = 1'b0;
   endtask

   // from disable with status high: R7
   task automatic t_restore;
      status = 1'b1;
      edges(2);
      check("R7 still disabled", int'(state), 2);
      edges(1);
      check("R7 restoring", int'(state), 3);
      check("R7 clk_en", int'(clk_en), 1);
      expect_quiet("R2 restoring outputs");
      edges(TC - 1);
      check("R7 before done", int'(state), 3);
      edges(1);
      check("R7 active", int'(state), 0);
   endtask

   task automatic t_passthrough;
      ctl_in = 2'b01; dat_in = 8'h3C;
      #1;
      check("R2 ctl pass", int'(ctl_out), 1);
      check("R2 dat pass", int'(dat_out), 8'h3C);
      ctl_in = 2'b11; dat_in = 8'hFF;
      #1;
      check("R2 ctl pass2", int'(ctl_out), 3);
      check("R2 dat pass2", int'(dat_out), 8'hFF);
   endtask

   task automatic t_short_pulses;
      for (int p = 0; p < 2; p++) begin
         status = 1'b0;
         edges(RC - 1);
         status = 1'b1;
         edges(1);
      end
      edges(RC + 10);
      check("R5 short pulses ignored", int'(state), 0);
      check("R5 clk_en", int'(clk_en), 1);
   endtask

   task automatic t_reset_entry;
      status = 1'b0;
      edges(RC + 2);
      check("R1 not yet", int'(state), 0);
      edges(1);
      check("R1 reset", int'(state), 1);
      check("R3 clk_en", int'(clk_en), 1);
      expect_quiet("R2 reset outputs");
   endtask

   task automatic t_reset_exit;
      status = 1'b1;
      edges(2);
      check("R6 still reset", int'(state), 1);
      edges(1);
      check("R6 active", int'(state), 0);
   endtask

   // continues a held low from edge RC+3
   task automatic t_disable_entry;
      edges(DC - RC - 1);
      check("R4 not yet", int'(state), 1);
      check("R3 clk_en long reset", int'(clk_en), 1);
      edges(1);
      check("R4 disabled", int'(state), 2);
      check("R4 clk_en", int'(clk_en), 0);
      expect_quiet("R2 disable outputs");
   endtask

   task automatic t_restore_glitch;
      status = 1'b1;
      edges(3 + 100);
      check("R8 restoring", int'(state), 3);
      status = 1'b0;
      @(posedge clk);
      @(negedge clk);
      status = 1'b1;
      edges(TC + 1);
      check("R8 restart holds", int'(state), 3);
      edges(1);
      check("R8 active", int'(state), 0);
   endtask

   initial begin
      edges(3);
      check("R9 boot state", int'(state), 2);
      check("R9 boot clk_en", int'(clk_en), 0);
      expect_quiet("R9 boot outputs");
      rst = 1'b0;
      t_restore();
      t_passthrough();
      t_short_pulses();
      t_reset_entry();
      t_reset_exit();
      t_reset_entry();
      t_disable_entry();
      t_restore();
      status = 1'b0;
      edges(DC + 3);
      check("R4 disabled again", int'(state), 2);
      t_restore_glitch();
      t_sync_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule